// File: doc/BRIEF.md
# Descriptor-Driven DMA Loop Engine

This block executes one DMA channel from a descriptor loaded on its configuration pins. The descriptor gives both addresses, their signed steps, beat sizes, circular-buffer widths, the byte count of one inner (minor) loop, the outer (major) iteration count, the end-of-run adjustments and a set of control bits. Each activation, by software trigger or by an enabled hardware request, runs one minor loop. That loop is a sequence of read beats, each followed by a write beat that carries the same data. When the last iteration finishes, the engine applies the end adjustments, reloads the iteration count and raises done.

Data leaves on two valid/ready channels. A read beat completes in the cycle where `rd_valid` and `rd_ready` are both high, and `rd_data` is taken in that cycle. A write beat completes when `wr_valid` and `wr_ready` are both high. The engine never withdraws a beat: while ready stays low, valid, address, size and write data hold steady. The side that responds may hold ready low for any number of cycles, and the engine waits. Control and status pins are plain levels or one-cycle pulses.

Top module: `dma_loop_engine`

## Requirements
- R1: A descriptor load is accepted only while idle, only when both size codes are legal (0=1 B, 1=2 B, 2=4 B, 4=16 B, 5=32 B) and only when the iteration count is non-zero. Any other load leaves the previous descriptor in force.
- R2: A minor loop starts from idle on `trig_sw`, or on `trig_hw` while `trig_enable` is set. `trig_enable_set` sets `trig_enable`. With `trig_enable` clear, `trig_hw` starts nothing.
- R3: Each read beat is followed by exactly one write beat. `wr_data` equals the data of the preceding read, the two channels are never valid together, and a stalled beat keeps its address and data.
- R4: After each accepted read, the source address adds the sign-extended 16-bit source step. After each accepted write, the destination address adds its own step in the same way.
- R5: A wrap code n in 1..31 lets only the low n address bits change on a step (a 2^n-byte ring). Code 0 disables wrapping.
- R6: `bytes_left` drops by the source beat size on each accepted read, saturating at 0. The minor loop ends after the write that follows the read which reached 0. While idle, `bytes_left` shows the programmed byte count.
- R7: At the end of each minor loop that is not the last, the signed loop adjustment is added to whichever of source and destination has it enabled, and `iter_left` decrements by one.
- R8: At the end of the last minor loop, the end adjustments are added to both addresses instead of the loop adjustment, `iter_left` reloads, `done` sets, and `irq_end` pulses if enabled. `done` clears when the next minor loop starts.
- R9: `irq_half`, if enabled, pulses once when `iter_left` decrements to half the starting count (rounded down) and that value is non-zero.
- R10: `link_valid` pulses with the loop-link channel after each non-final minor loop, and with the end-link channel after the final one, each only when its enable is set.
- R11: Throttle code 2 inserts 4 idle cycles and code 3 inserts 8 idle cycles after every accepted beat. Codes 0 and 1 insert none.
- R12: With auto-stop set, `trig_enable` clears at major completion, so a held `trig_hw` starts no further loops.
- R13: After reset the engine is idle, with no valid beats, pulses, done or trigger enable, and both counters read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Load the descriptor pins below |
| cfg_src | input | AW | Source start address |
| cfg_src_step | input | 16 | Signed source step per read |
| cfg_src_size | input | 3 | Source beat size code |
| cfg_src_wrap | input | 5 | Source ring width code |
| cfg_dst | input | AW | Destination start address |
| cfg_dst_step | input | 16 | Signed destination step per write |
| cfg_dst_size | input | 3 | Destination beat size code |
| cfg_dst_wrap | input | 5 | Destination ring width code |
| cfg_loop_bytes | input | NB_W | Bytes per minor loop |
| cfg_iters | input | IT_W | Minor loops per major loop |
| cfg_loop_adj | input | AW | Signed per-minor-loop adjustment |
| cfg_src_loop_adj_en | input | 1 | Apply loop adjustment to source |
| cfg_dst_loop_adj_en | input | 1 | Apply loop adjustment to destination |
| cfg_src_end_adj | input | AW | Source adjustment at major end |
| cfg_dst_end_adj | input | AW | Destination adjustment at major end |
| cfg_half_irq_en | input | 1 | Enable half-way pulse |
| cfg_end_irq_en | input | 1 | Enable major-end pulse |
| cfg_auto_stop | input | 1 | Clear trigger enable at major end |
| cfg_loop_link_en | input | 1 | Enable per-minor-loop link |
| cfg_loop_link_ch | input | CH_W | Channel for per-minor-loop link |
| cfg_end_link_en | input | 1 | Enable major-end link |
| cfg_end_link_ch | input | CH_W | Channel for major-end link |
| cfg_throttle | input | 2 | Idle cycles after each beat code |
| trig_enable_set | input | 1 | Set hardware trigger enable |
| trig_hw | input | 1 | Hardware request |
| trig_sw | input | 1 | Software start |
| rd_valid | output | 1 | Read beat request |
| rd_ready | input | 1 | Read beat accepted, data valid |
| rd_addr | output | AW | Read address |
| rd_size | output | 3 | Read size code |
| rd_data | input | DW | Read data |
| wr_valid | output | 1 | Write beat request |
| wr_ready | input | 1 | Write beat accepted |
| wr_addr | output | AW | Write address |
| wr_size | output | 3 | Write size code |
| wr_data | output | DW | Write data |
| busy | output | 1 | Minor loop in progress |
| done | output | 1 | Major loop finished |
| irq_half | output | 1 | Half-way pulse |
| irq_end | output | 1 | Major-end pulse |
| link_valid | output | 1 | Link trigger pulse |
| link_ch | output | CH_W | Linked channel number |
| trig_enable | output | 1 | Hardware trigger enable state |
| bytes_left | output | NB_W | Working byte counter |
| iter_left | output | IT_W | Current iteration count |

## Verification
The assertions assume that the responder drives `rd_data` valid whenever it raises `rd_ready`. They also assume that the loop byte count is a whole number of source beats, so each beat consumes its full size. A descriptor load is expected only while idle, and the assertions treat the registered descriptor as fixed during a run. The stimulus keeps to this: every vector's byte count is a multiple of its beat size, ready is held low only for whole cycles around a pending beat, and the one load issued while busy exists to show that it is ignored.

// File: rtl/dma_loop_pkg.sv
package dma_loop_pkg;

  localparam int STEP_W = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_RSTALL,
    ST_WR,
    ST_WSTALL,
    ST_MINOR
  } eng_state_t;

  // Legal beat size codes: 0,1,2,4,5 -> 1,2,4,16,32 bytes.
  function automatic logic size_legal(input logic [2:0] code);
    return (code <= 3'd2) || (code == 3'd4) || (code == 3'd5);
  endfunction

  function automatic logic [5:0] size_bytes(input logic [2:0] code);
    return 6'd1 << code;
  endfunction

  function automatic logic [3:0] stall_len(input logic [1:0] code);
    case (code)
      2'd2:    return 4'd4;
      2'd3:    return 4'd8;
      default: return 4'd0;
    endcase
  endfunction

endpackage

// File: rtl/dma_addr_step.sv
module dma_addr_step #(
  parameter int AW     = 32,
  parameter int STEP_W = 16
) (
  input  logic [AW-1:0]     addr,
  input  logic [STEP_W-1:0] step,
  input  logic [4:0]        wrap,
  output logic [AW-1:0]     next
);
  localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

  logic [AW-1:0] sum;
  logic [AW-1:0] ring;

  always_comb begin
    sum  = addr + {{(AW-STEP_W){step[STEP_W-1]}}, step};
    ring = (wrap == 5'd0) ? '1 : ((ONE << wrap) - ONE);
    next = (addr & ~ring) | (sum & ring);
  end
endmodule

// File: rtl/dma_throttle.sv
module dma_throttle
  import dma_loop_pkg::*;
#(
  parameter int CW = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       arm,
  input  logic [1:0] code,
  output logic       needed,
  output logic       last
);
  logic [CW-1:0] cnt;

  assign needed = (stall_len(code) != 4'd0);
  assign last   = (cnt == {{(CW-1){1'b0}}, 1'b1});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (arm)         cnt <= CW'(stall_len(code));
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  p_stall_max_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(8));
endmodule

// File: rtl/dma_iter_ctrl.sv
module dma_iter_ctrl #(
  parameter int IT_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [IT_W-1:0] load_val,
  input  logic            step,
  input  logic            half_en,
  input  logic            end_en,
  output logic [IT_W-1:0] cur,
  output logic            final_pass,
  output logic            half_pulse,
  output logic            end_pulse
);
  logic [IT_W-1:0] start;
  logic            loaded;
  logic [IT_W-1:0] dec;

  assign final_pass = (cur == {{(IT_W-1){1'b0}}, 1'b1});
  assign dec        = cur - 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur        <= '0;
      start      <= '0;
      loaded     <= 1'b0;
      half_pulse <= 1'b0;
      end_pulse  <= 1'b0;
    end else begin
      half_pulse <= 1'b0;
      end_pulse  <= 1'b0;
      if (load) begin
        cur    <= load_val;
        start  <= load_val;
        loaded <= 1'b1;
      end else if (step) begin
        if (final_pass) begin
          cur       <= start;
          end_pulse <= end_en;
        end else begin
          cur        <= dec;
          half_pulse <= half_en && (dec == (start >> 1));
        end
      end
    end
  end

  p_iter_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    loaded |-> (cur != '0) && (cur <= start));
  p_half_nonzero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    half_pulse |-> (cur != '0) && !final_pass || (cur == (start >> 1)));
endmodule

// File: rtl/dma_loop_engine.sv
module dma_loop_engine
  import dma_loop_pkg::*;
#(
  parameter int AW   = 32,
  parameter int DW   = 256,
  parameter int NB_W = 16,
  parameter int IT_W = 16,
  parameter int CH_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_load,
  input  logic [AW-1:0]    cfg_src,
  input  logic [15:0]      cfg_src_step,
  input  logic [2:0]       cfg_src_size,
  input  logic [4:0]       cfg_src_wrap,
  input  logic [AW-1:0]    cfg_dst,
  input  logic [15:0]      cfg_dst_step,
  input  logic [2:0]       cfg_dst_size,
  input  logic [4:0]       cfg_dst_wrap,
  input  logic [NB_W-1:0]  cfg_loop_bytes,
  input  logic [IT_W-1:0]  cfg_iters,
  input  logic [AW-1:0]    cfg_loop_adj,
  input  logic             cfg_src_loop_adj_en,
  input  logic             cfg_dst_loop_adj_en,
  input  logic [AW-1:0]    cfg_src_end_adj,
  input  logic [AW-1:0]    cfg_dst_end_adj,
  input  logic             cfg_half_irq_en,
  input  logic             cfg_end_irq_en,
  input  logic             cfg_auto_stop,
  input  logic             cfg_loop_link_en,
  input  logic [CH_W-1:0]  cfg_loop_link_ch,
  input  logic             cfg_end_link_en,
  input  logic [CH_W-1:0]  cfg_end_link_ch,
  input  logic [1:0]       cfg_throttle,
  input  logic             trig_enable_set,
  input  logic             trig_hw,
  input  logic             trig_sw,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [AW-1:0]    rd_addr,
  output logic [2:0]       rd_size,
  input  logic [DW-1:0]    rd_data,
  output logic             wr_valid,
  input  logic             wr_ready,
  output logic [AW-1:0]    wr_addr,
  output logic [2:0]       wr_size,
  output logic [DW-1:0]    wr_data,
  output logic             busy,
  output logic             done,
  output logic             irq_half,
  output logic             irq_end,
  output logic             link_valid,
  output logic [CH_W-1:0]  link_ch,
  output logic             trig_enable,
  output logic [NB_W-1:0]  bytes_left,
  output logic [IT_W-1:0]  iter_left
);
  localparam int PADB  = NB_W - 6;
  localparam int NPORT = 2;

  eng_state_t       state;
  logic [AW-1:0]    r_src, r_dst, r_loop_adj, r_src_end, r_dst_end;
  logic [15:0]      r_soff, r_doff;
  logic [2:0]       r_ssz, r_dsz;
  logic [4:0]       r_smod, r_dmod;
  logic [NB_W-1:0]  r_nbytes, r_bcnt;
  logic             r_sadj, r_dadj, r_auto, r_mlink, r_xlink, r_ok;
  logic [CH_W-1:0]  r_mch, r_xch;
  logic [1:0]       r_bwc;
  logic [DW-1:0]    r_buf;

  logic             load_ok, go, rd_acc, wr_acc;
  logic             thr_needed, thr_last, it_final;
  logic [NB_W-1:0]  sb;

  logic [AW-1:0]    st_cur [NPORT];
  logic [15:0]      st_off [NPORT];
  logic [4:0]       st_mod [NPORT];
  logic [AW-1:0]    st_nxt [NPORT];

  assign st_cur[0] = r_src;  assign st_off[0] = r_soff; assign st_mod[0] = r_smod;
  assign st_cur[1] = r_dst;  assign st_off[1] = r_doff; assign st_mod[1] = r_dmod;

  for (genvar g = 0; g < NPORT; g++) begin : g_step
    dma_addr_step #(.AW(AW), .STEP_W(STEP_W)) u_step (
      .addr (st_cur[g]),
      .step (st_off[g]),
      .wrap (st_mod[g]),
      .next (st_nxt[g])
    );
  end

  assign load_ok = cfg_load && (state == ST_IDLE) && size_legal(cfg_src_size) &&
                   size_legal(cfg_dst_size) && (cfg_iters != '0);
  assign go      = (state == ST_IDLE) && !cfg_load && r_ok &&
                   (trig_sw || (trig_hw && trig_enable));
  assign rd_acc  = rd_valid && rd_ready;
  assign wr_acc  = wr_valid && wr_ready;
  assign sb      = {{PADB{1'b0}}, size_bytes(r_ssz)};

  dma_throttle #(.CW(4)) u_thr (
    .clk    (clk),
    .rst_n  (rst_n),
    .arm    (rd_acc || wr_acc),
    .code   (r_bwc),
    .needed (thr_needed),
    .last   (thr_last)
  );

  dma_iter_ctrl #(.IT_W(IT_W)) u_iter (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load_ok),
    .load_val   (cfg_iters),
    .step       (state == ST_MINOR),
    .half_en    (cfg_half_en_q),
    .end_en     (cfg_end_en_q),
    .cur        (iter_left),
    .final_pass (it_final),
    .half_pulse (irq_half),
    .end_pulse  (irq_end)
  );

  logic cfg_half_en_q, cfg_end_en_q;

  assign rd_valid   = (state == ST_RD);
  assign wr_valid   = (state == ST_WR);
  assign rd_addr    = r_src;
  assign wr_addr    = r_dst;
  assign rd_size    = r_ssz;
  assign wr_size    = r_dsz;
  assign wr_data    = r_buf;
  assign busy       = (state != ST_IDLE);
  assign bytes_left = r_bcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      r_src <= '0; r_dst <= '0; r_loop_adj <= '0; r_src_end <= '0; r_dst_end <= '0;
      r_soff <= '0; r_doff <= '0; r_ssz <= '0; r_dsz <= '0; r_smod <= '0; r_dmod <= '0;
      r_nbytes <= '0; r_bcnt <= '0;
      r_sadj <= 1'b0; r_dadj <= 1'b0; r_auto <= 1'b0; r_mlink <= 1'b0; r_xlink <= 1'b0;
      r_ok <= 1'b0; r_mch <= '0; r_xch <= '0; r_bwc <= '0; r_buf <= '0;
      cfg_half_en_q <= 1'b0; cfg_end_en_q <= 1'b0;
      done <= 1'b0; trig_enable <= 1'b0; link_valid <= 1'b0; link_ch <= '0;
    end else begin
      link_valid <= 1'b0;
      if (trig_enable_set) trig_enable <= 1'b1;
      case (state)
        ST_IDLE: begin
          if (load_ok) begin
            r_src <= cfg_src;           r_dst <= cfg_dst;
            r_soff <= cfg_src_step;     r_doff <= cfg_dst_step;
            r_ssz <= cfg_src_size;      r_dsz <= cfg_dst_size;
            r_smod <= cfg_src_wrap;     r_dmod <= cfg_dst_wrap;
            r_nbytes <= cfg_loop_bytes; r_bcnt <= cfg_loop_bytes;
            r_loop_adj <= cfg_loop_adj;
            r_sadj <= cfg_src_loop_adj_en; r_dadj <= cfg_dst_loop_adj_en;
            r_src_end <= cfg_src_end_adj;  r_dst_end <= cfg_dst_end_adj;
            cfg_half_en_q <= cfg_half_irq_en; cfg_end_en_q <= cfg_end_irq_en;
            r_auto <= cfg_auto_stop;
            r_mlink <= cfg_loop_link_en; r_mch <= cfg_loop_link_ch;
            r_xlink <= cfg_end_link_en;  r_xch <= cfg_end_link_ch;
            r_bwc <= cfg_throttle;
            r_ok <= 1'b1;
            done <= 1'b0;
          end else if (go) begin
            state <= ST_RD;
            done  <= 1'b0;
          end
        end
        ST_RD: begin
          if (rd_ready) begin
            r_buf  <= rd_data;
            r_src  <= st_nxt[0];
            r_bcnt <= (r_bcnt <= sb) ? '0 : r_bcnt - sb;
            state  <= thr_needed ? ST_RSTALL : ST_WR;
          end
        end
        ST_RSTALL: begin
          if (thr_last) state <= ST_WR;
        end
        ST_WR: begin
          if (wr_ready) begin
            r_dst <= st_nxt[1];
            if (thr_needed)          state <= ST_WSTALL;
            else if (r_bcnt == '0)   state <= ST_MINOR;
            else                     state <= ST_RD;
          end
        end
        ST_WSTALL: begin
          if (thr_last) state <= (r_bcnt == '0) ? ST_MINOR : ST_RD;
        end
        ST_MINOR: begin
          r_bcnt <= r_nbytes;
          state  <= ST_IDLE;
          if (it_final) begin
            r_src <= r_src + r_src_end;
            r_dst <= r_dst + r_dst_end;
            done  <= 1'b1;
            if (r_auto) trig_enable <= 1'b0;
            if (r_xlink) begin
              link_valid <= 1'b1;
              link_ch    <= r_xch;
            end
          end else begin
            if (r_sadj) r_src <= r_src + r_loop_adj;
            if (r_dadj) r_dst <= r_dst + r_loop_adj;
            if (r_mlink) begin
              link_valid <= 1'b1;
              link_ch    <= r_mch;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_rd_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> rd_valid && $stable(rd_addr));
  p_wr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> wr_valid && $stable(wr_addr) && $stable(wr_data));
  p_one_side_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_valid && wr_valid));
  p_wrap_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && (r_smod != 5'd0)) |=> (((r_src ^ $past(r_src)) >> r_smod) == '0));
  p_idle_bytes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> (bytes_left == r_nbytes));
  p_end_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_end |-> done);
  p_link_origin_r10: assert property (@(posedge clk) disable iff (!rst_n)
    link_valid |-> $past(state == ST_MINOR));
  p_gap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && (r_bwc == 2'd3)) |=> !wr_valid);
endmodule

// File: tb/sim_dma_loop_engine.sv
`timescale 1ns/1ps
module sim_dma_loop_engine;
  typedef struct packed {
    logic [31:0] saddr;  logic [15:0] soff; logic [2:0] ssz; logic [4:0] smod;
    logic [31:0] daddr;  logic [15:0] doff; logic [2:0] dsz; logic [4:0] dmod;
    logic [15:0] nb;     logic [15:0] it;
    logic [31:0] slast;  logic [31:0] dlast; logic [31:0] mloff;
    logic        smlo;   logic        dmlo;  logic [1:0]  bwc;
    logic [31:0] exp_src; logic [31:0] exp_dst;
    logic [15:0] exp_reads; logic [3:0] exp_gap; logic [3:0] exp_half;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{32'h1000, 16'd4, 3'd2, 5'd0, 32'h2000, 16'd4, 3'd2, 5'd0, 16'd8, 16'd2,
      32'hFFFF_FFF0, 32'h0, 32'h0, 1'b0, 1'b0, 2'd0, 32'h1000, 32'h2010, 16'd4, 4'd0, 4'd1},
    '{32'h100C, 16'd4, 3'd2, 5'd4, 32'h3000, 16'd0, 3'd2, 5'd0, 16'd12, 16'd1,
      32'h0, 32'h0, 32'h0, 1'b0, 1'b0, 2'd2, 32'h1008, 32'h3000, 16'd3, 4'd4, 4'd0},
    '{32'h4000, 16'hFFFE, 3'd1, 5'd0, 32'h5000, 16'd2, 3'd1, 5'd0, 16'd4, 16'd3,
      32'h0, 32'h40, 32'h100, 1'b0, 1'b1, 2'd3, 32'h3FF4, 32'h524C, 16'd6, 4'd8, 4'd1},
    '{32'h8000, 16'd32, 3'd5, 5'd0, 32'h9000, 16'd32, 3'd5, 5'd0, 16'd64, 16'd1,
      32'hFFFF_FFC0, 32'hFFFF_FFC0, 32'h0, 1'b0, 1'b0, 2'd0, 32'h8000, 32'h9000, 16'd2, 4'd0, 4'd0},
    '{32'hA000, 16'd16, 3'd4, 5'd0, 32'hB010, 16'd16, 3'd4, 5'd5, 16'd32, 16'd1,
      32'h0, 32'h0, 32'h0, 1'b0, 1'b0, 2'd2, 32'hA020, 32'hB010, 16'd2, 4'd4, 4'd0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic cfg_load = 0;
  logic [31:0] cfg_src = 0, cfg_dst = 0, cfg_loop_adj = 0, cfg_src_end_adj = 0, cfg_dst_end_adj = 0;
  logic [15:0] cfg_src_step = 0, cfg_dst_step = 0, cfg_loop_bytes = 0, cfg_iters = 0;
  logic [2:0]  cfg_src_size = 0, cfg_dst_size = 0;
  logic [4:0]  cfg_src_wrap = 0, cfg_dst_wrap = 0, cfg_loop_link_ch = 5'd5, cfg_end_link_ch = 5'd9;
  logic cfg_src_loop_adj_en = 0, cfg_dst_loop_adj_en = 0, cfg_half_irq_en = 1, cfg_end_irq_en = 1;
  logic cfg_auto_stop = 0, cfg_loop_link_en = 1, cfg_end_link_en = 1;
  logic [1:0] cfg_throttle = 0;
  logic trig_enable_set = 0, trig_hw = 0, trig_sw = 0;
  logic rd_rdy_en = 1, wr_rdy_en = 1;

  logic rd_valid, wr_valid, busy, done, irq_half, irq_end, link_valid, trig_enable;
  logic [31:0] rd_addr, wr_addr;
  logic [2:0] rd_size, wr_size;
  logic [255:0] rd_data, wr_data;
  logic [4:0] link_ch;
  logic [15:0] bytes_left, iter_left;

  function automatic logic [255:0] pat(input logic [31:0] a);
    return {8{a ^ 32'h5A5A_0000}};
  endfunction
  assign rd_data = pat(rd_addr);

  dma_loop_engine u0 (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_src(cfg_src), .cfg_src_step(cfg_src_step),
    .cfg_src_size(cfg_src_size), .cfg_src_wrap(cfg_src_wrap), .cfg_dst(cfg_dst),
    .cfg_dst_step(cfg_dst_step), .cfg_dst_size(cfg_dst_size), .cfg_dst_wrap(cfg_dst_wrap),
    .cfg_loop_bytes(cfg_loop_bytes), .cfg_iters(cfg_iters), .cfg_loop_adj(cfg_loop_adj),
    .cfg_src_loop_adj_en(cfg_src_loop_adj_en), .cfg_dst_loop_adj_en(cfg_dst_loop_adj_en),
    .cfg_src_end_adj(cfg_src_end_adj), .cfg_dst_end_adj(cfg_dst_end_adj),
    .cfg_half_irq_en(cfg_half_irq_en), .cfg_end_irq_en(cfg_end_irq_en), .cfg_auto_stop(cfg_auto_stop),
    .cfg_loop_link_en(cfg_loop_link_en), .cfg_loop_link_ch(cfg_loop_link_ch),
    .cfg_end_link_en(cfg_end_link_en), .cfg_end_link_ch(cfg_end_link_ch), .cfg_throttle(cfg_throttle),
    .trig_enable_set(trig_enable_set), .trig_hw(trig_hw), .trig_sw(trig_sw),
    .rd_valid(rd_valid), .rd_ready(rd_rdy_en), .rd_addr(rd_addr), .rd_size(rd_size), .rd_data(rd_data),
    .wr_valid(wr_valid), .wr_ready(wr_rdy_en), .wr_addr(wr_addr), .wr_size(wr_size), .wr_data(wr_data),
    .busy(busy), .done(done), .irq_half(irq_half), .irq_end(irq_end), .link_valid(link_valid),
    .link_ch(link_ch), .trig_enable(trig_enable), .bytes_left(bytes_left), .iter_left(iter_left)
  );

  int n_chk = 0, n_fail = 0;
  int n_rd = 0, n_half = 0, n_end = 0, n_mlink = 0, n_xlink = 0, bad_link = 0, data_err = 0;
  int last_gap = 0, g = 0;
  bit measuring = 0;
  logic [31:0] last_rd = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (rd_valid && rd_rdy_en) begin
        n_rd++; last_rd = rd_addr; measuring = 1; g = 0;
      end else if (measuring) begin
        if (wr_valid) begin last_gap = g; measuring = 0; end
        else g++;
      end
      if (wr_valid && wr_rdy_en && (wr_data != pat(last_rd))) data_err++;
      if (irq_half) n_half++;
      if (irq_end) n_end++;
      if (link_valid) begin
        if (link_ch == 5'd5) n_mlink++;
        else if (link_ch == 5'd9) n_xlink++;
        else bad_link++;
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic load_vec(input vec_t v);
    @(negedge clk);
    cfg_src = v.saddr; cfg_src_step = v.soff; cfg_src_size = v.ssz; cfg_src_wrap = v.smod;
    cfg_dst = v.daddr; cfg_dst_step = v.doff; cfg_dst_size = v.dsz; cfg_dst_wrap = v.dmod;
    cfg_loop_bytes = v.nb; cfg_iters = v.it; cfg_src_end_adj = v.slast; cfg_dst_end_adj = v.dlast;
    cfg_loop_adj = v.mloff; cfg_src_loop_adj_en = v.smlo; cfg_dst_loop_adj_en = v.dmlo;
    cfg_throttle = v.bwc; cfg_load = 1;
    @(negedge clk);
    cfg_load = 0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run_minor();
    @(negedge clk); trig_sw = 1;
    @(negedge clk); trig_sw = 0;
    wait_idle();
  endtask

  task automatic run_vec(input int idx);
    vec_t v;
    int b_rd, b_half, b_end, b_ml, b_xl;
    v = VECS[idx];
    cfg_auto_stop = 0;
    load_vec(v);
    b_rd = n_rd; b_half = n_half; b_end = n_end; b_ml = n_mlink; b_xl = n_xlink;
    for (int k = 0; k < int'(v.it); k++) run_minor();
    chk($sformatf("R6 reads v%0d", idx), n_rd - b_rd, v.exp_reads);
    chk($sformatf("R11 gap v%0d", idx), last_gap, v.exp_gap);
    chk($sformatf("R9 half v%0d", idx), n_half - b_half, v.exp_half);
    chk($sformatf("R8 end pulse and done v%0d", idx), {n_end - b_end, 31'd0, done}, {32'd1, 31'd0, 1'b1});
    chk($sformatf("R10 links v%0d", idx), {n_mlink - b_ml, n_xlink - b_xl}, {int'(v.it) - 1, 32'd1});
    chk($sformatf("R8 iteration reload v%0d", idx), iter_left, v.it);
    rd_rdy_en = 0;
    @(negedge clk); trig_sw = 1;
    @(negedge clk); trig_sw = 0;
    chk($sformatf("R4 R5 R7 R8 src v%0d", idx), {rd_valid, rd_addr}, {1'b1, v.exp_src});
    rd_rdy_en = 1;
    while (!wr_valid) @(negedge clk);
    chk($sformatf("R4 R5 R7 R8 dst v%0d", idx), wr_addr, v.exp_dst);
    wait_idle();
  endtask

  initial begin : watchdog
    for (int c = 0; c < 60000; c++) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R13 reset state
    chk("R13 reset", {busy, done, rd_valid, wr_valid, link_valid, trig_enable, irq_half, irq_end,
                      bytes_left, iter_left}, 64'd0);
    rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < 5; i++) run_vec(i);

    // R1 / R3 / R6 directed
    load_vec(VECS[0]);
    @(negedge clk);
    cfg_src = 32'hDEAD_0000; cfg_src_size = 3'd3; cfg_load = 1;
    @(negedge clk); cfg_load = 0; cfg_src_size = 3'd2;
    rd_rdy_en = 0; wr_rdy_en = 0;
    @(negedge clk); trig_sw = 1;
    @(negedge clk); trig_sw = 0;
    chk("R1 reserved size load ignored", rd_addr, 32'h1000);
    chk("R6 working count before read", bytes_left, 16'd8);
    repeat (3) @(negedge clk);
    chk("R3 read held under back-pressure", {rd_valid, wr_valid, rd_addr}, {2'b10, 32'h1000});
    rd_rdy_en = 1;
    @(negedge clk); rd_rdy_en = 0;
    chk("R6 count after one read", bytes_left, 16'd4);
    chk("R3 write follows read", {rd_valid, wr_valid}, 2'b01);
    cfg_src = 32'hDEAD_0000; cfg_load = 1;
    @(negedge clk); cfg_load = 0;
    repeat (2) @(negedge clk);
    chk("R3 write held under back-pressure", {wr_valid, wr_addr}, {1'b1, 32'h2000});
    rd_rdy_en = 1; wr_rdy_en = 1;
    wait_idle();
    rd_rdy_en = 0;
    @(negedge clk); trig_sw = 1;
    @(negedge clk); trig_sw = 0;
    chk("R1 load while busy ignored, R7 address", rd_addr, 32'h1008);
    rd_rdy_en = 1;
    wait_idle();

    // R2 / R12 directed
    cfg_auto_stop = 1;
    load_vec(VECS[3]);
    trig_hw = 1;
    repeat (5) @(negedge clk);
    chk("R2 hw request without enable", busy, 1'b0);
    trig_enable_set = 1;
    @(negedge clk); trig_enable_set = 0;
    chk("R2 enable set", trig_enable, 1'b1);
    @(negedge clk);
    chk("R2 hw request starts loop", busy, 1'b1);
    wait_idle();
    repeat (5) @(negedge clk);
    chk("R12 auto-stop clears enable", {trig_enable, busy, done}, 3'b001);
    trig_hw = 0;

    chk("R3 write data matches read data", data_err, 0);
    chk("R10 no stray link channel", bad_link, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule